// File: doc/BRIEF.md
# Dual-Mode Timer with Watchdog Lock

This block is a 16-bit timer running on a slow, low-power clock through a selectable prescaler. It works either as a general periodic timer that counts up or down and raises a sticky interrupt, or as a watchdog. In watchdog mode it counts down from the reload value. On timeout it either requests a system reset or raises the interrupt. Software must keep it from timing out by writing to a clear strobe.

Software sees four items: a reload register, a read-only current count, an 8-bit configuration register and a write-only clear strobe. Watchdog mode locks the reload and configuration registers until a power-on reset. The secondary reset input returns the block to its defaults only while the watchdog is not engaged; once it is engaged, that reset is ignored and counting continues. A debug-halt input freezes counting. Counting during power-down is optional and selected by a configuration bit.

A small state machine holds the mode. It has three states. `ST_IDLE` means the timer is stopped. `ST_RUN` means the timer runs in normal mode. `ST_WDOG` means the watchdog is engaged.

The transitions are:
- `ST_IDLE` to `ST_RUN`: a configuration write with the enable bit set and the watchdog bit clear.
- `ST_RUN` to `ST_IDLE`: a configuration write with the enable bit clear.
- `ST_IDLE` or `ST_RUN` to `ST_WDOG`: a configuration write with the watchdog bit set.
- `ST_IDLE` or `ST_RUN` to `ST_IDLE`: the secondary reset.
- `ST_WDOG` holds until power-on reset. Power-on reset forces `ST_IDLE` from any state.

Top module: `dmt_wdog_timer`

## Requirements
- R1: After power-on reset the reload value and the count both read 0x0040, the configuration reads 0x00, and both irq and rst_req are low.
- R2: Configuration bits [3:2] select the prescaler: 00 divides by 1, 01 by 16, 10 by 256 and 11 by 256. The counter steps once for every that many active clock cycles, counted from the last reload.
- R3: In normal mode, configuration bit 7 enables counting. Bit 6 selects up counting (1) or down counting (0). A step taken at the terminal value (0x0000 when counting down, 0xFFFF when counting up) reloads the count from the reload register and sets irq.
- R4: A write of any data to the clear strobe reloads the count from the reload register on the same edge, clears irq and restarts the prescaler. It takes priority over a step in the same cycle.
- R5: irq stays set until a clear write or a reset.
- R6: A configuration write with bit 5 set enters watchdog mode. Entry loads the count from the reload register, and from then on the counter counts down, whatever bits 7 and 6 hold. A step at 0x0000 reloads the count. If bit 1 is 1, that step raises rst_req; if bit 1 is 0, it sets irq.
- R7: In watchdog mode, writes to the reload and configuration registers are ignored. Only power-on reset clears this lock, after which writes are accepted again.
- R8: The secondary reset returns all registers and the count to their power-on values while the block is not in watchdog mode. In watchdog mode it is ignored, and counting goes on unchanged.
- R9: While dbg_halt is high, neither the count nor the prescaler advances. Counting resumes when dbg_halt falls.
- R10: With configuration bit 0 clear, counting continues while pwr_down is high. With bit 0 set, counting freezes while pwr_down is high.
- R11: rst_req is a single-cycle pulse. The counter has already reloaded by then, so the next timeout starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow low-power timer clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | Secondary reset, synchronous, active low |
| wr_load | input | 1 | Write strobe for the reload register |
| wr_cfg | input | 1 | Write strobe for the configuration register |
| wr_clear | input | 1 | Write strobe for the clear/kick register (data ignored) |
| wdata | input | 16 | Write data bus |
| dbg_halt | input | 1 | Debugger halt, freezes counting |
| pwr_down | input | 1 | Power-down indication |
| rd_load | output | 16 | Reload register value |
| rd_cfg | output | 8 | Configuration register value |
| rd_count | output | 16 | Current count |
| irq | output | 1 | Sticky interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A register write or clear takes effect on the edge that samples its strobe. The count begins stepping on the first edge after the configuration write that makes the block active. irq and rst_req rise on the same edge as the terminal step's reload, so they can be seen half a cycle later. The bench drives strobes and samples on falling edges, and counts rising edges between stimulus and check, using the prescaler ratio in force. Each expected value goes into a scoreboard queue and is compared at the falling edge where it is due.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int CFG_W       = 8;
    localparam int CFG_PD_STOP = 0;
    localparam int CFG_WD_RST  = 1;
    localparam int CFG_PS_LO   = 2;
    localparam int CFG_WD_MODE = 5;
    localparam int CFG_UP      = 6;
    localparam int CFG_EN      = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WDOG = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/dmt_prescale.sv
module dmt_prescale #(
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       restart,
    input  logic       advance,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PS_W = HI_LOG;
    localparam logic [PS_W-1:0] LIM_MID = PS_W'((1 << MID_LOG) - 1);
    localparam logic [PS_W-1:0] LIM_HI  = PS_W'((1 << HI_LOG) - 1);

    logic [PS_W-1:0] pre_q;
    logic [PS_W-1:0] lim;

    always_comb begin
        unique case (sel)
            2'b00:   lim = '0;
            2'b01:   lim = LIM_MID;
            default: lim = LIM_HI;
        endcase
    end

    assign tick = advance && (pre_q == lim);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (tick)    pre_q <= '0;
        else if (advance) pre_q <= pre_q + 1'b1;
    end

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!advance && !restart) |=> $stable(pre_q));
endmodule

// File: rtl/dmt_fsm.sv
module dmt_fsm
    import dmt_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output tmr_state_e       state,
    output logic             active,
    output logic             locked,
    output logic             enter_wd
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_RUN: begin
                    if (cfg_wr && cfg_wdata[CFG_WD_MODE]) state_d = ST_WDOG;
                    else if (cfg_wr)
                        state_d = cfg_wdata[CFG_EN] ? ST_RUN : ST_IDLE;
                end
                ST_WDOG: state_d = ST_WDOG;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state    = state_q;
        active   = (state_q == ST_RUN) || (state_q == ST_WDOG);
        locked   = (state_q == ST_WDOG);
        enter_wd = (state_q != ST_WDOG) && (state_d == ST_WDOG);
    end

    // R7
    wd_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_WDOG) |=> (state_q == ST_WDOG));
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = W'(16'h0040)
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         soft_rst,
    input  logic         reload_now,
    input  logic         step,
    input  logic         up,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic at_term;

    assign at_term = up ? (&cnt) : (cnt == '0);
    assign wrap    = step && at_term && !reload_now && !soft_rst;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          cnt <= RST_VAL;
        else if (soft_rst)   cnt <= RST_VAL;
        else if (reload_now) cnt <= load_val;
        else if (step) begin
            if (at_term)     cnt <= load_val;
            else if (up)     cnt <= cnt + 1'b1;
            else             cnt <= cnt - 1'b1;
        end
    end

    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        wrap |=> (cnt == $past(load_val)));
endmodule

// File: rtl/dmt_wdog_timer.sv
module dmt_wdog_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             wr_load,
    input  logic             wr_cfg,
    input  logic             wr_clear,
    input  logic [CNT_W-1:0] wdata,
    input  logic             dbg_halt,
    input  logic             pwr_down,
    output logic [CNT_W-1:0] rd_load,
    output logic [CFG_W-1:0] rd_cfg,
    output logic [CNT_W-1:0] rd_count,
    output logic             irq,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(16'h0040);

    tmr_state_e       state;
    logic             active, locked, enter_wd;
    logic             soft_rst, reload_now, advance, tick, wrap, up_cnt;
    logic [CNT_W-1:0] load_q;
    logic [CFG_W-1:0] cfg_q;
    logic             irq_q, rst_q;

    assign soft_rst   = !sys_rst_n && !locked;
    assign reload_now = wr_clear || enter_wd;
    assign advance    = active && !dbg_halt && !(pwr_down && cfg_q[CFG_PD_STOP]);
    assign up_cnt     = (state == ST_RUN) && cfg_q[CFG_UP];

    dmt_fsm u_fsm (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .cfg_wr(wr_cfg),
        .cfg_wdata(wdata[CFG_W-1:0]), .state(state), .active(active),
        .locked(locked), .enter_wd(enter_wd)
    );

    dmt_prescale #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_pre (
        .clk(clk), .por_n(por_n), .restart(reload_now || soft_rst),
        .advance(advance), .sel(cfg_q[CFG_PS_LO +: 2]), .tick(tick)
    );

    dmt_counter #(.W(CNT_W), .RST_VAL(DEF_VAL)) u_cnt (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .reload_now(reload_now),
        .step(tick), .up(up_cnt), .load_val(load_q), .cnt(rd_count), .wrap(wrap)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            load_q <= DEF_VAL;
            cfg_q  <= '0;
        end else if (soft_rst) begin
            load_q <= DEF_VAL;
            cfg_q  <= '0;
        end else if (!locked) begin
            if (wr_load) load_q <= wdata;
            if (wr_cfg)  cfg_q  <= wdata[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            rst_q <= wrap && locked && cfg_q[CFG_WD_RST];
            if (soft_rst || wr_clear) irq_q <= 1'b0;
            else if (wrap && !(locked && cfg_q[CFG_WD_RST])) irq_q <= 1'b1;
        end
    end

    assign rd_load = load_q;
    assign rd_cfg  = cfg_q;
    assign irq     = irq_q;
    assign rst_req = rst_q;

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (irq && !wr_clear && !soft_rst) |=> irq);
    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);
    // R6
    rst_only_wd_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> locked);
    // R7
    lock_regs_chk: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> ($stable(rd_cfg) && $stable(rd_load)));
    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_halt && !wr_clear && !soft_rst && !enter_wd) |=> $stable(rd_count));
endmodule

// File: tb/dmt_wdog_timer_tb_top.sv
module dmt_wdog_timer_tb_top;
    localparam int CLK_P = 10;
    localparam int K_CNT = 0, K_IRQ = 1, K_RST = 2, K_CFG = 3, K_LOAD = 4;
    localparam int W_LOAD = 0, W_CFG = 1, W_CLR = 2;

    typedef struct {
        int          kind;
        logic [15:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1;
    logic        wr_load = 1'b0, wr_cfg = 1'b0, wr_clear = 1'b0;
    logic [15:0] wdata = '0;
    logic        dbg_halt = 1'b0, pwr_down = 1'b0;
    logic [15:0] rd_load, rd_count;
    logic [7:0]  rd_cfg;
    logic        irq, rst_req;

    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    event chk_ev;

    always #(CLK_P/2) clk = ~clk;

    dmt_wdog_timer dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_load(wr_load),
        .wr_cfg(wr_cfg), .wr_clear(wr_clear), .wdata(wdata), .dbg_halt(dbg_halt),
        .pwr_down(pwr_down), .rd_load(rd_load), .rd_cfg(rd_cfg),
        .rd_count(rd_count), .irq(irq), .rst_req(rst_req)
    );

    function automatic logic [15:0] actual(int kind);
        case (kind)
            K_CNT:   return rd_count;
            K_IRQ:   return {15'd0, irq};
            K_RST:   return {15'd0, rst_req};
            K_CFG:   return {8'd0, rd_cfg};
            default: return rd_load;
        endcase
    endfunction

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [15:0] a;
                it = sb_q.pop_front();
                a  = actual(it.kind);
                n_cmp++;
                if (a !== it.val) begin
                    n_bad++;
                    $display("FAIL %s: kind %0d actual 0x%04h expected 0x%04h",
                             it.tag, it.kind, a, it.val);
                end
            end
        end
    end

    task automatic expect_val(int kind, logic [15:0] v, string tag);
        exp_t it;
        it.kind = kind; it.val = v; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int which, logic [15:0] d);
        wdata    = d;
        wr_load  = (which == W_LOAD);
        wr_cfg   = (which == W_CFG);
        wr_clear = (which == W_CLR);
        @(negedge clk);
        wr_load = 1'b0; wr_cfg = 1'b0; wr_clear = 1'b0;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic ps_case(logic [7:0] cfg, int div, string tag);
        wr(W_CFG, 16'h0000);
        wr(W_CLR, 16'h0000);
        wr(W_CFG, {8'd0, cfg});
        expect_val(K_CNT, 16'd3, tag);
        step(div - 1);
        expect_val(K_CNT, 16'd3, tag);
        step(1);
        expect_val(K_CNT, 16'd2, tag);
    endtask

    initial begin
        step(3);
        por_n = 1'b1;
        // R1
        expect_val(K_CNT, 16'h0040, "R1");
        expect_val(K_LOAD, 16'h0040, "R1");
        expect_val(K_CFG, 16'h0000, "R1");
        expect_val(K_IRQ, 16'd0, "R1");
        expect_val(K_RST, 16'd0, "R1");

        // R3 down count, divide by 1
        wr(W_LOAD, 16'd5);
        wr(W_CLR, 16'h00AA);
        wr(W_CFG, 16'h0080);
        expect_val(K_CNT, 16'd5, "R3");
        step(3);
        expect_val(K_CNT, 16'd2, "R3");
        step(3);
        expect_val(K_CNT, 16'd5, "R3");
        expect_val(K_IRQ, 16'd1, "R3");
        step(4);
        expect_val(K_IRQ, 16'd1, "R5");
        // R4 clear reloads and drops irq
        wr(W_CLR, 16'h0011);
        expect_val(K_CNT, 16'd5, "R4");
        expect_val(K_IRQ, 16'd0, "R4");

        // R3 up count
        wr(W_CFG, 16'h0000);
        wr(W_LOAD, 16'hFFFD);
        wr(W_CLR, 16'h0000);
        wr(W_CFG, 16'h00C0);
        expect_val(K_CNT, 16'hFFFD, "R3");
        step(2);
        expect_val(K_CNT, 16'hFFFF, "R3");
        step(1);
        expect_val(K_CNT, 16'hFFFD, "R3");
        expect_val(K_IRQ, 16'd1, "R3");

        // R2 prescaler ratios
        wr(W_CFG, 16'h0000);
        wr(W_LOAD, 16'd3);
        ps_case(8'h84, 16, "R2");
        ps_case(8'h88, 256, "R2");
        ps_case(8'h8C, 256, "R2");
        expect_val(K_IRQ, 16'd0, "R4");

        // R9 debug halt, R10 power-down
        wr(W_CFG, 16'h0000);
        wr(W_LOAD, 16'h0100);
        wr(W_CLR, 16'h0000);
        wr(W_CFG, 16'h0080);
        dbg_halt = 1'b1;
        step(5);
        expect_val(K_CNT, 16'h0100, "R9");
        dbg_halt = 1'b0;
        step(2);
        expect_val(K_CNT, 16'h00FE, "R9");
        pwr_down = 1'b1;
        step(2);
        expect_val(K_CNT, 16'h00FC, "R10");
        wr(W_CFG, 16'h0081);
        expect_val(K_CNT, 16'h00FB, "R10");
        step(4);
        expect_val(K_CNT, 16'h00FB, "R10");
        pwr_down = 1'b0;
        step(1);
        expect_val(K_CNT, 16'h00FA, "R10");

        // R8 secondary reset outside watchdog mode
        sys_rst_n = 1'b0;
        step(1);
        sys_rst_n = 1'b1;
        expect_val(K_CFG, 16'h0000, "R8");
        expect_val(K_LOAD, 16'h0040, "R8");
        expect_val(K_CNT, 16'h0040, "R8");

        // R6 watchdog with reset request, R7 lock
        wr(W_LOAD, 16'd4);
        wr(W_CFG, 16'h0022);
        expect_val(K_CNT, 16'd4, "R6");
        expect_val(K_CFG, 16'h0022, "R6");
        wr(W_CFG, 16'h0000);
        expect_val(K_CFG, 16'h0022, "R7");
        expect_val(K_CNT, 16'd3, "R6");
        wr(W_LOAD, 16'd9);
        expect_val(K_LOAD, 16'd4, "R7");
        expect_val(K_CNT, 16'd2, "R6");
        step(2);
        expect_val(K_CNT, 16'd0, "R6");
        expect_val(K_RST, 16'd0, "R11");
        step(1);
        expect_val(K_RST, 16'd1, "R6");
        expect_val(K_IRQ, 16'd0, "R6");
        expect_val(K_CNT, 16'd4, "R11");
        step(1);
        expect_val(K_RST, 16'd0, "R11");
        expect_val(K_CNT, 16'd3, "R11");
        wr(W_CLR, 16'h0000);
        expect_val(K_CNT, 16'd4, "R4");
        sys_rst_n = 1'b0;
        step(1);
        sys_rst_n = 1'b1;
        expect_val(K_CNT, 16'd3, "R8");
        expect_val(K_CFG, 16'h0022, "R8");
        step(1);
        expect_val(K_CNT, 16'd2, "R8");

        // R6 watchdog with interrupt
        do_por();
        expect_val(K_CFG, 16'h0000, "R7");
        expect_val(K_CNT, 16'h0040, "R1");
        wr(W_LOAD, 16'd2);
        wr(W_CFG, 16'h0020);
        expect_val(K_CNT, 16'd2, "R6");
        step(2);
        expect_val(K_CNT, 16'd0, "R6");
        step(1);
        expect_val(K_IRQ, 16'd1, "R6");
        expect_val(K_RST, 16'd0, "R6");
        expect_val(K_CNT, 16'd2, "R6");
        wr(W_CLR, 16'h0000);
        expect_val(K_IRQ, 16'd0, "R4");
        expect_val(K_CNT, 16'd2, "R4");

        // R7 power-on reset releases the lock
        do_por();
        wr(W_CFG, 16'h0080);
        expect_val(K_CFG, 16'h0080, "R7");
        wr(W_LOAD, 16'h1234);
        expect_val(K_LOAD, 16'h1234, "R7");

        #1;
        -> chk_ev;
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule